// File: doc/BRIEF.md
# Dual Cascadable Interval Timer

This block holds two down-counting interval timers, A and B, each 16 bits wide by default. Each timer has a reload latch written byte by byte, a small control register, and a one-cycle event pulse that goes to an interrupt collector. One clock cycle of `clk` is one processor bus cycle. Timer A counts either every cycle or the qualified rising edges of an external count input. Timer B counts either every cycle or each underflow of timer A, so the two timers can be chained into one 32-bit interval.

Each timer can run in continuous mode, where an underflow reloads the counter and counting goes on, or in one-shot mode, where an underflow reloads the counter and stops the timer by clearing its start bit. Software writes registers through a write strobe with an address. The selected register is read back combinationally on `rd_data`.

Top module: `dual_interval_timer`

## Requirements
- R1: After reset both counters and both latches read 0xFFFF, both control registers read 0x00, and both event outputs are low.
- R2: In continuous mode (control bit 1 = 0), a started timer decrements once per tick. When a tick finds the counter at zero, the counter reloads from the latch and the event output is high for exactly the next cycle. The period is therefore latch+1 ticks.
- R3: In one-shot mode (control bit 1 = 1), an underflow reloads the counter from the latch, raises the event, and clears the start bit (control bit 0). After that the counter holds its value.
- R4: With a latch of zero and the start bit set on a per-cycle source, the timer underflows and its event output is high on every cycle.
- R5: Writing a control byte with bit 2 set copies the latch into the counter at that write's clock edge and raises no event. Bit 2 always reads back as 0.
- R6: A write to the high latch byte while the timer is stopped also loads the whole counter from the latch. While the timer runs, such a write only changes the latch.
- R7: With timer A control bit 3 set, timer A counts rising edges of `cnt_in` after a two-stage synchronizer. A level held for many cycles counts once. The highest count rate is one per two cycles.
- R8: With timer B control bit 3 set, timer B decrements once per timer A underflow. Its event appears exactly one cycle after the timer A event that caused it.
- R9: Register map: address 0/1 is timer A low/high (read counter, write latch), 2/3 is timer B low/high, 4 is timer A control, 5 is timer B control, and 6 and 7 read 0. Control bits are 0 start, 1 one-shot, 2 force-load, 3 source select.
- R10: A stopped timer holds its counter value while no register is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | DW (8) | Write data byte |
| rd_data | output | DW (8) | Combinational read data of the addressed register |
| cnt_in | input | 1 | External count input for timer A |
| evt_a | output | 1 | Timer A underflow event pulse |
| evt_b | output | 1 | Timer B underflow event pulse |

## Verification
The bench targets the zero-latch case, where an off-by-one underflow test would either stall the timer or produce an event only every other cycle. It also targets the one-shot stop, where a design that forgets to clear the start bit keeps reloading and firing. For the cascade, a timer B that sampled the raw underflow instead of the registered event would fire in the same cycle as timer A and would break the one-cycle lag. The bench also checks that a force-load does not raise a spurious event, that a high-byte write to a running timer does not disturb the count, and that a long high level on the count input counts only once rather than on every cycle.

// File: rtl/itimer_pkg.sv
`timescale 1ns/1ps
package itimer_pkg;
  localparam int CTL_START   = 0;
  localparam int CTL_ONESHOT = 1;
  localparam int CTL_FORCE   = 2;
  localparam int CTL_SRC     = 3;

  typedef struct packed {
    logic src;
    logic oneshot;
    logic start;
  } tctl_t;
endpackage

// File: rtl/edge_qualifier.sv
`timescale 1ns/1ps
module edge_qualifier #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise
);
  logic [SYNC:0] stage;

  always_ff @(posedge clk) begin
    if (!rst_n) stage <= '0;
    else        stage <= {stage[SYNC-1:0], din};
  end

  assign rise = stage[SYNC-1] & ~stage[SYNC];
endmodule

// File: rtl/interval_counter.sv
`timescale 1ns/1ps
module interval_counter
  import itimer_pkg::*;
#(
  parameter int DW = 8,
  localparam int W = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          lo_we,
  input  logic          hi_we,
  input  logic          ctl_we,
  input  logic [DW-1:0] wdata,
  output logic [W-1:0]  count,
  output logic [W-1:0]  latch,
  output tctl_t         ctl,
  output logic          evt,
  output logic          under,
  output logic          force_ld
);
  function automatic logic [W-1:0] next_count(input logic [W-1:0] cur,
                                                input logic [W-1:0] rl);
    return (cur == '0) ? rl : cur - W'(1);
  endfunction

  logic load_hi;

  assign force_ld = ctl_we & wdata[CTL_FORCE];
  assign under    = ctl.start & tick & (count == '0) & ~force_ld;
  assign load_hi  = hi_we & ~ctl.start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '1;
      latch <= '1;
      ctl   <= '0;
      evt   <= 1'b0;
    end else begin
      evt <= under;
      if (lo_we) latch[DW-1:0] <= wdata;
      if (hi_we) latch[W-1:DW] <= wdata;

      if (force_ld)                count <= latch;
      else if (load_hi)            count <= {wdata, latch[DW-1:0]};
      else if (ctl.start && tick)  count <= next_count(count, latch);

      if (ctl_we) begin
        ctl.start   <= wdata[CTL_START];
        ctl.oneshot <= wdata[CTL_ONESHOT];
        ctl.src     <= wdata[CTL_SRC];
      end else if (under && ctl.oneshot) begin
        ctl.start <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dual_interval_timer.sv
`timescale 1ns/1ps
module dual_interval_timer
  import itimer_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] rd_data,
  input  logic          cnt_in,
  output logic          evt_a,
  output logic          evt_b
);
  localparam int W  = 2 * DW;
  localparam int NT = 2;

  logic [W-1:0] cnt_w   [NT];
  logic [W-1:0] latch_w [NT];
  tctl_t        ctl_w   [NT];
  logic [NT-1:0] evt_w, under_w, force_w, tick_w, ctl_we_w;
  logic          ext_edge;

  edge_qualifier #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(cnt_in), .rise(ext_edge)
  );

  // Timer A ticks on cycles or qualified input edges; B on cycles or A events.
  assign tick_w[0] = ctl_w[0].src ? ext_edge : 1'b1;
  assign tick_w[1] = ctl_w[1].src ? evt_w[0] : 1'b1;

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    logic lo_we, hi_we;
    assign lo_we       = wr_en && (addr == 3'(2*t));
    assign hi_we       = wr_en && (addr == 3'(2*t + 1));
    assign ctl_we_w[t] = wr_en && (addr == 3'(4 + t));

    interval_counter #(.DW(DW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(tick_w[t]),
      .lo_we(lo_we), .hi_we(hi_we), .ctl_we(ctl_we_w[t]), .wdata(wr_data),
      .count(cnt_w[t]), .latch(latch_w[t]), .ctl(ctl_w[t]),
      .evt(evt_w[t]), .under(under_w[t]), .force_ld(force_w[t])
    );
  end

  assign evt_a = evt_w[0];
  assign evt_b = evt_w[1];

  always_comb begin
    rd_data = '0;
    case (addr)
      3'd0: rd_data = cnt_w[0][DW-1:0];
      3'd1: rd_data = cnt_w[0][W-1:DW];
      3'd2: rd_data = cnt_w[1][DW-1:0];
      3'd3: rd_data = cnt_w[1][W-1:DW];
      3'd4: rd_data = DW'({ctl_w[0].src, 1'b0, ctl_w[0].oneshot, ctl_w[0].start});
      3'd5: rd_data = DW'({ctl_w[1].src, 1'b0, ctl_w[1].oneshot, ctl_w[1].start});
      default: rd_data = '0;
    endcase
  end

  // Named internal events for the bound checker
  logic [W-1:0] cnt_a, latch_a;
  logic under_a, start_a, oneshot_a, src_b, tick_a, force_a, ctl_we_a;
  assign cnt_a     = cnt_w[0];
  assign latch_a   = latch_w[0];
  assign under_a   = under_w[0];
  assign start_a   = ctl_w[0].start;
  assign oneshot_a = ctl_w[0].oneshot;
  assign src_b     = ctl_w[1].src;
  assign tick_a    = tick_w[0];
  assign force_a   = force_w[0];
  assign ctl_we_a  = ctl_we_w[0];
endmodule

// File: rtl/dual_interval_timer_chk.sv
`timescale 1ns/1ps
module dual_interval_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic         evt_a,
  input logic         evt_b,
  input logic         ext_edge,
  input logic         under_a,
  input logic         start_a,
  input logic         oneshot_a,
  input logic         src_b,
  input logic         tick_a,
  input logic         force_a,
  input logic         ctl_we_a,
  input logic [W-1:0] cnt_a,
  input logic [W-1:0] latch_a
);
  assert_reload_R2: assert property (@(posedge clk) disable iff (!rst_n)
    evt_a && !$past(wr_en) |-> cnt_a == latch_a);

  assert_countdown_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_a && tick_a && !under_a && !wr_en |=> cnt_a == $past(cnt_a) - W'(1));

  assert_oneshot_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    under_a && oneshot_a && !ctl_we_a |=> !start_a);

  assert_force_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    force_a |=> !evt_a);

  assert_edge_rate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ext_edge |=> !ext_edge);

  assert_cascade_lag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt_b && $past(src_b) |-> $past(evt_a));

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !start_a && !wr_en |=> $stable(cnt_a));
endmodule

bind dual_interval_timer dual_interval_timer_chk #(.W(2*DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .evt_a(evt_a), .evt_b(evt_b),
  .ext_edge(ext_edge), .under_a(under_a), .start_a(start_a),
  .oneshot_a(oneshot_a), .src_b(src_b), .tick_a(tick_a), .force_a(force_a),
  .ctl_we_a(ctl_we_a), .cnt_a(cnt_a), .latch_a(latch_a)
);

// File: tb/dual_interval_timer_test.sv
`timescale 1ns/1ps
module dual_interval_timer_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wr_data = 8'd0;
  logic [7:0] rd_data;
  logic       cnt_in = 1'b0;
  logic       evt_a, evt_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  dual_interval_timer uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .cnt_in(cnt_in), .evt_a(evt_a), .evt_b(evt_b)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0; cnt_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Called at a negedge; write lands on the following posedge.
  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1; d = rd_data;
  endtask

  task automatic rd16(input int t, output int v);
    logic [7:0] lo, hi;
    rd(3'(2*t), lo);
    rd(3'(2*t+1), hi);
    v = {hi, lo};
  endtask

  task automatic test_reset();
    logic [7:0] d;
    do_reset();
    for (int a = 0; a < 3; a++) begin rd(3'(a), d); chk("R1", "reset counter byte", d, 8'hFF); end
    step(); rd(3'd3, d); chk("R1", "reset B high", d, 8'hFF);
    rd(3'd4, d); chk("R9", "reset ctrl A", d, 0);
    rd(3'd5, d); chk("R9", "reset ctrl B", d, 0);
    step(); rd(3'd6, d); chk("R9", "unused addr 6", d, 0);
    rd(3'd7, d); chk("R9", "unused addr 7", d, 0);
    chk("R1", "reset evt_a", evt_a, 0);
    chk("R1", "reset evt_b", evt_b, 0);
  endtask

  task automatic test_continuous();
    int v, m;
    logic e;
    do_reset();
    wr(3'd0, 8'd3); wr(3'd1, 8'd0); wr(3'd4, 8'h01);
    rd16(0, v); chk("R2", "start value", v, 3);
    m = 3;
    for (int i = 0; i < 10; i++) begin
      step();
      if (m == 0) begin m = 3; e = 1'b1; end else begin m--; e = 1'b0; end
      rd16(0, v);
      chk("R2", "continuous count", v, m);
      chk("R2", "continuous event", evt_a, e);
    end
  endtask

  task automatic test_oneshot();
    int v;
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'd2); wr(3'd1, 8'd0); wr(3'd4, 8'h03);
    step(); step();
    rd16(0, v); chk("R3", "one-shot reaches zero", v, 0);
    step();
    rd16(0, v); chk("R3", "one-shot reload", v, 2);
    chk("R3", "one-shot event", evt_a, 1);
    rd(3'd4, d); chk("R3", "start bit cleared", d, 8'h02);
    repeat (4) step();
    rd16(0, v); chk("R3", "one-shot holds after stop", v, 2);
    chk("R3", "no further event", evt_a, 0);
  endtask

  task automatic test_zero_latch();
    int v;
    do_reset();
    wr(3'd0, 8'd0); wr(3'd1, 8'd0); wr(3'd4, 8'h01);
    for (int i = 0; i < 5; i++) begin
      step();
      chk("R4", "event every cycle", evt_a, 1);
      rd16(0, v); chk("R4", "counter stays zero", v, 0);
    end
  endtask

  task automatic test_force_and_hi();
    int v;
    logic [7:0] d;
    do_reset();
    wr(3'd0, 8'd100); wr(3'd1, 8'd0); wr(3'd4, 8'h01);
    step(); step();
    wr(3'd0, 8'h40);
    wr(3'd4, 8'h05);
    rd16(0, v); chk("R5", "force load value", v, 8'h40);
    chk("R5", "force load no event", evt_a, 0);
    rd(3'd4, d); chk("R5", "force bit reads zero", d, 8'h01);
    wr(3'd1, 8'h01);
    rd16(0, v); chk("R6", "high write while running keeps count", v, 8'h3F);
    wr(3'd4, 8'h00);
    rd16(0, v); chk("R6", "last decrement before stop", v, 8'h3E);
    wr(3'd1, 8'h02);
    rd16(0, v); chk("R6", "high write while stopped loads", v, 16'h0240);
    repeat (3) step();
    rd16(0, v); chk("R10", "stopped timer holds", v, 16'h0240);
  endtask

  task automatic test_external();
    int v;
    do_reset();
    wr(3'd0, 8'd9); wr(3'd1, 8'd0); wr(3'd4, 8'h09);
    repeat (4) step();
    rd16(0, v); chk("R7", "no count without edges", v, 9);
    for (int i = 0; i < 3; i++) begin
      cnt_in = 1'b1; step(); cnt_in = 1'b0; step();
    end
    repeat (4) step();
    rd16(0, v); chk("R7", "fastest toggling counts each pulse", v, 6);
    cnt_in = 1'b1; repeat (6) step();
    rd16(0, v); chk("R7", "held high counts once", v, 5);
    cnt_in = 1'b0; repeat (4) step();
    rd16(0, v); chk("R7", "falling edge not counted", v, 5);
  endtask

  task automatic test_cascade();
    int v, ma, mb;
    logic ea, eb, bt;
    do_reset();
    wr(3'd0, 8'd2); wr(3'd1, 8'd0); wr(3'd2, 8'd1); wr(3'd3, 8'd0);
    wr(3'd5, 8'h09); wr(3'd4, 8'h01);
    ma = 2; mb = 1; ea = 1'b0; eb = 1'b0;
    for (int i = 0; i < 16; i++) begin
      step();
      bt = ea;
      eb = bt && (mb == 0);
      if (bt) mb = (mb == 0) ? 1 : mb - 1;
      ea = (ma == 0);
      ma = (ma == 0) ? 2 : ma - 1;
      chk("R8", "timer A event", evt_a, ea);
      chk("R8", "timer B event lags A", evt_b, eb);
      rd16(1, v); chk("R8", "timer B counts A underflows", v, mb);
    end
  endtask

  initial begin
    test_reset();
    test_continuous();
    test_oneshot();
    test_zero_latch();
    test_force_and_hi();
    test_external();
    test_cascade();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule